// File: doc/BRIEF.md
# Four-Window Priority Background Compositor

This block sits in the pixel pipeline of an on-screen display that lays text over a 15-row by 30-column character grid. For every pixel position it decides whether one of four rectangular windows, each spanning a range of character rows and columns, covers that pixel. It returns the background color to paint, a flag that a window or a window shadow is being drawn, and a flag that the pixel belongs to a drop shadow. Glyph rendering happens elsewhere and is merged downstream.

Each window is held in three 8-bit configuration bytes, written through a simple write strobe. Overlapping windows are resolved by a fixed priority. Each window can throw an L-shaped drop shadow whose width and height are chosen per window. All shadows share one color. A clear strobe turns every window off at once. The outputs are registered one cycle after the position inputs.

Top module: `osd_win_compositor`

## Requirements
- R1: A write with `cfg_wr` high stores `cfg_wdata` at `cfg_addr`. Address 3*k+0 holds window k's row start in bits [7:4] and its row end in bits [3:0]. Address 3*k+1 holds the column start in [7:3], the enable in bit 2 and the shadow enable in bit 1. Address 3*k+2 holds the column end in [7:3] and the RGB color in [2:0]. Window k=0 is window 1. Addresses 12 to 15 are ignored.
- R2: While `rst_n` is low at a clock edge, every configuration field, including all enable and shadow bits, clears to 0. After that edge all three outputs are 0.
- R3: A `win_clear` pulse clears all four enable bits and leaves the other fields untouched. When a write to an enable byte falls in the same cycle, the clear wins.
- R4: A pixel whose character row lies between row start and row end and whose column lies between column start and column end (bounds inclusive) of an enabled window with a nonzero color gives `bg_rgb` equal to that window's color, with `win_active`=1 and `win_shadow`=0.
- R5: A window whose row start exceeds its row end, or whose column start exceeds its column end, draws neither body nor shadow.
- R6: Where several bodies cover a pixel, the window with the lowest number wins.
- R7: A window body with color 000 is transparent, so lower-priority windows show through it.
- R8: With its shadow bit set, a window casts a shadow over the area its body would cover if shifted right by W pixels and down by H lines, minus the body area. W is 2, 4, 6 or 8 pixels for width code 0 to 3, taken from `shd_wcode[2k+1:2k]`. H is 2, 4, 6 or 8 lines for the height code in `shd_hcode[2k+1:2k]`. Shadow pixels give `bg_rgb`=`shd_rgb`, `win_active`=1 and `win_shadow`=1.
- R9: A shadow ranks at its own window's priority. A higher-priority body hides it, and it covers lower-priority bodies.
- R10: The outputs reflect the position presented at the previous rising clock edge. They change only at a clock edge. With no window covering the pixel, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_row | input | 4 | Character row of the current pixel |
| pos_col | input | 5 | Character column of the current pixel |
| pos_px | input | 4 | Pixel offset inside the character cell (0..11) |
| pos_line | input | 7 | Line offset inside the character row |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address (3 per window) |
| cfg_wdata | input | 8 | Configuration byte to write |
| win_clear | input | 1 | Clear all window enables |
| shd_wcode | input | 8 | Shadow width codes, 2 bits per window |
| shd_hcode | input | 8 | Shadow height codes, 2 bits per window |
| shd_rgb | input | 3 | Shared shadow color |
| bg_rgb | output | 3 | Background color for the pixel |
| win_active | output | 1 | Window body or shadow drawn |
| win_shadow | output | 1 | Pixel is a drop shadow |

## Verification
Two functions can fall in the same cycle. A clear strobe can coincide with a write that sets window 1's enable bit. The bench drives both in one clock. It then looks at a pixel inside window 1: that pixel must show no background, and rewriting only the enable byte must bring the window back in its old place and color. The second case is a lower-priority body lying under a higher-priority shadow, or a shadow lying under a higher-priority body. Pixels are placed in those overlaps, and the judge is which color and shadow flag appear one cycle later.

// File: rtl/osd_win_pkg.sv
// Shared widths and the per-window configuration record of the window
// compositor. Assumes a 16-row by 32-column addressable grid.
package osd_win_pkg;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 5;
    localparam int PIX_W  = 4;
    localparam int LINE_W = 7;
    localparam int RGB_W  = 3;
    localparam int CODE_W = 2;
    localparam int BYTES_PER_WIN = 3;

    typedef struct packed {
        logic [ROW_W-1:0] row_lo;
        logic [ROW_W-1:0] row_hi;
        logic [COL_W-1:0] col_lo;
        logic             enable;
        logic             shd_on;
        logic [COL_W-1:0] col_hi;
        logic [RGB_W-1:0] color;
    } win_cfg_t;
endpackage

// File: rtl/osd_win_regs.sv
// Configuration store for NUM_WIN windows, three bytes each. A clear strobe
// drops every enable bit and takes precedence over a same-cycle write.
// Assumes byte writes arrive one per cycle.
module osd_win_regs
    import osd_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = $clog2(BYTES_PER_WIN*NUM_WIN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       clr_en,
    output win_cfg_t [NUM_WIN-1:0]     cfg_o
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BYTES_PER_WIN*i);

        // Capture addressed bytes; clear strobe overrides the enable bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[i] <= '0;
            end else begin
                if (wr_en && wr_addr == BASE) begin
                    cfg_o[i].row_lo <= wr_data[7:4];
                    cfg_o[i].row_hi <= wr_data[3:0];
                end
                if (wr_en && wr_addr == BASE + 1'b1) begin
                    cfg_o[i].col_lo <= wr_data[7:3];
                    cfg_o[i].enable <= wr_data[2];
                    cfg_o[i].shd_on <= wr_data[1];
                end
                if (wr_en && wr_addr == BASE + 2'd2) begin
                    cfg_o[i].col_hi <= wr_data[7:3];
                    cfg_o[i].color  <= wr_data[2:0];
                end
                if (clr_en) begin
                    cfg_o[i].enable <= 1'b0;
                end
            end
        end

        // R3
        clear_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en |=> !cfg_o[i].enable);

        // R2
        reset_clears_cfg_chk: assert property (@(posedge clk)
            !rst_n |=> cfg_o[i] == '0);
    end
endmodule

// File: rtl/osd_win_hit.sv
// Geometry test of one window against one pixel position. Body covers the
// inclusive row/column rectangle; shadow covers the rectangle shifted right
// and down by the shadow size, minus the body. Purely combinational.
module osd_win_hit
    import osd_win_pkg::*;
(
    input  win_cfg_t             cfg,
    input  logic [ROW_W-1:0]     row,
    input  logic [COL_W-1:0]     col,
    input  logic [PIX_W-1:0]     px,
    input  logic [LINE_W-1:0]    line,
    input  logic [CODE_W-1:0]    wcode,
    input  logic [CODE_W-1:0]    hcode,
    output logic                 body_o,
    output logic                 shadow_o
);
    logic               valid;
    logic [PIX_W-1:0]   shd_w;
    logic [LINE_W-1:0]  shd_h;
    logic               in_rows, in_cols;
    logic               sh_rows, sh_cols;

    // Decode size codes and the start-not-after-end validity rule.
    always_comb begin
        shd_w = PIX_W'((32'(wcode) + 1) * 2);
        shd_h = LINE_W'((32'(hcode) + 1) * 2);
        valid = cfg.enable && (cfg.row_lo <= cfg.row_hi) && (cfg.col_lo <= cfg.col_hi);
    end

    // Body rectangle and shifted (shadow) rectangle membership.
    always_comb begin
        in_rows = (row >= cfg.row_lo) && (row <= cfg.row_hi);
        in_cols = (col >= cfg.col_lo) && (col <= cfg.col_hi);
        sh_rows = (in_rows && (row != cfg.row_lo || line >= shd_h)) ||
                  (({1'b0, row} == {1'b0, cfg.row_hi} + 1'b1) && line < shd_h);
        sh_cols = (in_cols && (col != cfg.col_lo || px >= shd_w)) ||
                  (({1'b0, col} == {1'b0, cfg.col_hi} + 1'b1) && px < shd_w);
    end

    // Final flags: transparent bodies never hit, shadows need their bit.
    always_comb begin
        body_o   = valid && (cfg.color != '0) && in_rows && in_cols;
        shadow_o = valid && cfg.shd_on && sh_rows && sh_cols && !(in_rows && in_cols);
    end
endmodule

// File: rtl/osd_win_mux.sv
// Priority merge of per-window hits and output register. Index 0 has the
// highest priority; a shadow ranks at its own window's level.
module osd_win_mux
    import osd_win_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_WIN-1:0]              body,
    input  logic [NUM_WIN-1:0]              shadow,
    input  logic [NUM_WIN-1:0][RGB_W-1:0]   color,
    input  logic [RGB_W-1:0]                shd_rgb,
    output logic [RGB_W-1:0]                rgb_o,
    output logic                            active_o,
    output logic                            shadow_o
);
    logic [RGB_W-1:0] rgb_d;
    logic             act_d, shd_d;

    // Walk from lowest to highest priority so the highest hit is last.
    always_comb begin
        rgb_d = '0;
        act_d = 1'b0;
        shd_d = 1'b0;
        for (int i = NUM_WIN-1; i >= 0; i--) begin
            if (body[i]) begin
                rgb_d = color[i];
                act_d = 1'b1;
                shd_d = 1'b0;
            end else if (shadow[i]) begin
                rgb_d = shd_rgb;
                act_d = 1'b1;
                shd_d = 1'b1;
            end
        end
    end

    // Register the merged result, one cycle behind the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_o    <= '0;
            active_o <= 1'b0;
            shadow_o <= 1'b0;
        end else begin
            rgb_o    <= rgb_d;
            active_o <= act_d;
            shadow_o <= shd_d;
        end
    end

    // R8
    shadow_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_o |-> (active_o && rgb_o == $past(shd_rgb)));

    // R7
    body_nonblack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !shadow_o) |-> rgb_o != '0);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (rgb_o == '0 && !shadow_o));
endmodule

// File: rtl/osd_win_compositor.sv
// Top of the window compositor: configuration store, one geometry tester
// per window, and the priority merge with registered outputs.
module osd_win_compositor
    import osd_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int ADDR_W = $clog2(BYTES_PER_WIN*NUM_WIN),
    localparam int CODES_W = CODE_W*NUM_WIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROW_W-1:0]     pos_row,
    input  logic [COL_W-1:0]     pos_col,
    input  logic [PIX_W-1:0]     pos_px,
    input  logic [LINE_W-1:0]    pos_line,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic                 win_clear,
    input  logic [CODES_W-1:0]   shd_wcode,
    input  logic [CODES_W-1:0]   shd_hcode,
    input  logic [RGB_W-1:0]     shd_rgb,
    output logic [RGB_W-1:0]     bg_rgb,
    output logic                 win_active,
    output logic                 win_shadow
);
    win_cfg_t [NUM_WIN-1:0]            cfg;
    logic [NUM_WIN-1:0]                body, shadow;
    logic [NUM_WIN-1:0][RGB_W-1:0]     color;

    osd_win_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .clr_en  (win_clear),
        .cfg_o   (cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_hit
        osd_win_hit u_hit (
            .cfg      (cfg[i]),
            .row      (pos_row),
            .col      (pos_col),
            .px       (pos_px),
            .line     (pos_line),
            .wcode    (shd_wcode[CODE_W*i +: CODE_W]),
            .hcode    (shd_hcode[CODE_W*i +: CODE_W]),
            .body_o   (body[i]),
            .shadow_o (shadow[i])
        );
        assign color[i] = cfg[i].color;
    end

    osd_win_mux #(.NUM_WIN(NUM_WIN)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .body     (body),
        .shadow   (shadow),
        .color    (color),
        .shd_rgb  (shd_rgb),
        .rgb_o    (bg_rgb),
        .active_o (win_active),
        .shadow_o (win_shadow)
    );
endmodule

// File: tb/osd_win_compositor_test.sv
`timescale 1ns/1ps
module osd_win_compositor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pos_row = '0;
    logic [4:0] pos_col = '0;
    logic [3:0] pos_px = '0;
    logic [6:0] pos_line = '0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       win_clear = 1'b0;
    logic [7:0] shd_wcode = 8'h39;
    logic [7:0] shd_hcode = 8'h30;
    logic [2:0] shd_rgb = 3'b110;
    logic [2:0] bg_rgb;
    logic       win_active, win_shadow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osd_win_compositor uut (
        .clk(clk), .rst_n(rst_n), .pos_row(pos_row), .pos_col(pos_col),
        .pos_px(pos_px), .pos_line(pos_line), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .win_clear(win_clear),
        .shd_wcode(shd_wcode), .shd_hcode(shd_hcode), .shd_rgb(shd_rgb),
        .bg_rgb(bg_rgb), .win_active(win_active), .win_shadow(win_shadow)
    );

    // {req, row, col, px, line, rgb, active, shadow}
    localparam int NV = 26;
    localparam logic [28:0] VEC [NV] = '{
        {4'd10, 4'd0,  5'd0,  4'd0,  7'd0,  3'd0, 1'b0, 1'b0},  // R10 empty
        {4'd6,  4'd2,  5'd5,  4'd0,  7'd0,  3'd4, 1'b1, 1'b0},  // R6 W1 over W2
        {4'd4,  4'd4,  5'd8,  4'd11, 7'd20, 3'd4, 1'b1, 1'b0},  // R4 W1 corner
        {4'd1,  4'd1,  5'd4,  4'd0,  7'd0,  3'd2, 1'b1, 1'b0},  // R1 W2 body
        {4'd4,  4'd3,  5'd3,  4'd11, 7'd9,  3'd2, 1'b1, 1'b0},  // R4 W2 edge
        {4'd8,  4'd0,  5'd7,  4'd3,  7'd1,  3'd0, 1'b0, 1'b0},  // R8 above band
        {4'd8,  4'd0,  5'd7,  4'd3,  7'd2,  3'd6, 1'b1, 1'b1},  // R8 W2 right
        {4'd8,  4'd1,  5'd7,  4'd6,  7'd0,  3'd0, 1'b0, 1'b0},  // R8 width 6 end
        {4'd8,  4'd1,  5'd7,  4'd5,  7'd0,  3'd6, 1'b1, 1'b1},  // R8 width 6 last
        {4'd9,  4'd3,  5'd7,  4'd0,  7'd0,  3'd4, 1'b1, 1'b0},  // R9 W1 hides W2 shadow
        {4'd8,  4'd4,  5'd3,  4'd5,  7'd0,  3'd0, 1'b0, 1'b0},  // R8 left of band
        {4'd8,  4'd4,  5'd3,  4'd6,  7'd1,  3'd6, 1'b1, 1'b1},  // R8 W2 below
        {4'd8,  4'd4,  5'd4,  4'd0,  7'd2,  3'd0, 1'b0, 1'b0},  // R8 height 2 end
        {4'd8,  4'd2,  5'd9,  4'd3,  7'd5,  3'd6, 1'b1, 1'b1},  // R8 W1 right
        {4'd8,  4'd2,  5'd9,  4'd4,  7'd5,  3'd0, 1'b0, 1'b0},  // R8 width 4 end
        {4'd9,  4'd5,  5'd8,  4'd0,  7'd1,  3'd6, 1'b1, 1'b1},  // R9 W1 below
        {4'd8,  4'd5,  5'd5,  4'd3,  7'd1,  3'd0, 1'b0, 1'b0},  // R8 shift left edge
        {4'd8,  4'd5,  5'd5,  4'd4,  7'd1,  3'd6, 1'b1, 1'b1},  // R8 shift start
        {4'd7,  4'd11, 5'd21, 4'd0,  7'd0,  3'd1, 1'b1, 1'b0},  // R7 W3 transparent
        {4'd9,  4'd11, 5'd23, 4'd7,  7'd5,  3'd6, 1'b1, 1'b1},  // R9 W3 shadow over W4
        {4'd8,  4'd11, 5'd23, 4'd8,  7'd5,  3'd1, 1'b1, 1'b0},  // R8 width 8 end
        {4'd8,  4'd13, 5'd21, 4'd0,  7'd7,  3'd6, 1'b1, 1'b1},  // R8 height 8
        {4'd8,  4'd13, 5'd21, 4'd0,  7'd8,  3'd1, 1'b1, 1'b0},  // R8 height 8 end
        {4'd4,  4'd14, 5'd25, 4'd0,  7'd0,  3'd0, 1'b0, 1'b0},  // R4 outside W4
        {4'd4,  4'd9,  5'd19, 4'd0,  7'd0,  3'd1, 1'b1, 1'b0},  // R4 W4 start
        {4'd4,  4'd13, 5'd25, 4'd11, 7'd30, 3'd1, 1'b1, 1'b0}   // R4 W4 end
    };

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got rgb/act/shd=%b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic clr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; win_clear = clr;
        @(negedge clk);
        cfg_wr = 1'b0; win_clear = 1'b0;
    endtask

    task automatic probe(input string req, input logic [3:0] r, input logic [4:0] c,
                         input logic [3:0] p, input logic [6:0] l, input logic [4:0] exp);
        @(negedge clk);
        pos_row = r; pos_col = c; pos_px = p; pos_line = l;
        @(negedge clk);
        check(req, {bg_rgb, win_active, win_shadow}, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset outputs", {bg_rgb, win_active, win_shadow}, 5'b0);
        rst_n = 1'b1;
        // R1 configuration of four windows
        wr(4'd0, 8'h24, 1'b0); wr(4'd1, 8'h2E, 1'b0); wr(4'd2, 8'h44, 1'b0);
        wr(4'd3, 8'h03, 1'b0); wr(4'd4, 8'h1E, 1'b0); wr(4'd5, 8'h32, 1'b0);
        wr(4'd6, 8'hAC, 1'b0); wr(4'd7, 8'hA6, 1'b0); wr(4'd8, 8'hB0, 1'b0);
        wr(4'd9, 8'h9D, 1'b0); wr(4'd10, 8'h9C, 1'b0); wr(4'd11, 8'hC9, 1'b0);
        wr(4'd12, 8'hFF, 1'b0); wr(4'd15, 8'hFF, 1'b0); // R1 unused addresses

        for (int i = 0; i < NV; i++) begin
            probe($sformatf("R%0d vector %0d", VEC[i][28:25], i),
                  VEC[i][24:21], VEC[i][20:16], VEC[i][15:12], VEC[i][11:5], VEC[i][4:0]);
        end

        // R10: output holds until the next rising edge
        probe("R10 setup", 4'd2, 5'd5, 4'd0, 7'd0, 5'b100_1_0);
        @(negedge clk);
        pos_row = 4'd0; pos_col = 5'd0;
        #1;
        check("R10 held before edge", {bg_rgb, win_active, win_shadow}, 5'b100_1_0);
        @(negedge clk);
        check("R10 updated after edge", {bg_rgb, win_active, win_shadow}, 5'b0);

        // R5 row start after row end on W4; W3 shadow unaffected
        wr(4'd9, 8'hED, 1'b0);
        probe("R5 row order", 4'd11, 5'd21, 4'd0, 7'd0, 5'b0);
        probe("R5 other window kept", 4'd11, 5'd23, 4'd7, 7'd5, 5'b110_1_1);
        // R5 column start after column end on W2
        wr(4'd5, 8'h12, 1'b0);
        probe("R5 column order", 4'd1, 5'd4, 4'd0, 7'd0, 5'b0);
        probe("R5 no shadow", 4'd1, 5'd7, 4'd5, 7'd0, 5'b0);

        // R3 clear coincides with enable write: clear wins
        wr(4'd1, 8'h2E, 1'b1);
        probe("R3 clear beats write", 4'd2, 5'd5, 4'd0, 7'd0, 5'b0);
        probe("R3 W3 cleared", 4'd11, 5'd23, 4'd7, 7'd5, 5'b0);
        wr(4'd1, 8'h2E, 1'b0);
        probe("R3 fields kept", 4'd4, 5'd8, 4'd11, 7'd0, 5'b100_1_0);
        probe("R3 shadow kept", 4'd2, 5'd9, 4'd3, 7'd5, 5'b110_1_1);

        // R2 reset mid-run clears enables
        @(negedge clk);
        pos_row = 4'd2; pos_col = 5'd5; pos_px = 4'd0; pos_line = 7'd0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 outputs in reset", {bg_rgb, win_active, win_shadow}, 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 enables cleared", {bg_rgb, win_active, win_shadow}, 5'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule